// File: doc/BRIEF.md
# Reconfigurable Approximate DCT Array (8/16/32 points)

This block computes a multiplier-free approximate discrete cosine transform on 32 signed samples per transaction. A two-bit mode chooses the layout: one 32-point transform, two independent 16-point transforms over the lower and upper sixteen samples, or four independent 8-point transforms over consecutive groups of eight. All three layouts share the same four 8-point kernel cores. A stage of sum/difference butterflies either feeds those cores or is bypassed, so larger transforms are built by recursive halving.

The 8-point kernel is the rounded, doubled 8-point DCT basis. Its entries are 0 or ±1, so every core is an adder tree. An N-point stage adds and subtracts mirrored sample pairs. The sum half goes to one N/2-point transform, which produces the even coefficients. The difference half goes to a second N/2-point transform with the same kernel, which produces the odd coefficients. Normalisation and quantisation are left to the consumer.

The block is a four-stage pipeline: input capture, the 32-point butterfly, the 16-point butterflies, and then the cores with the output reordering. The mode travels with its data. A new transaction may enter on every cycle.

Top module: `dct_rcfg_array`

## Requirements
- R1: Mode 2'b00 yields four 8-point transforms: out_data[8c+k] is kernel row k applied to in_data[8c..8c+7], for c = 0..3 and k = 0..7.
- R2: The 8-point kernel entry at row r, column c is round(2·e_r·sqrt(2/8)·cos((2c+1)rπ/16)), with e_0 = 1/sqrt(2) and e_r = 1 otherwise. Every entry is 0, +1 or −1.
- R3: Mode 2'b01 yields two 16-point transforms. For half h (samples 16h..16h+15, local index i = 0..15), a(i) = x(i)+x(15−i) and b(i) = x(i)−x(15−i) for i = 0..7. Then out_data[16h+2k] is kernel row k applied to a, and out_data[16h+2k+1] is kernel row k applied to b.
- R4: Mode 2'b11 yields one 32-point transform. First A(i) = x(i)+x(31−i) and B(i) = x(i)−x(31−i) for i = 0..15. Then out_data[2m] is coefficient m of the R3 16-point transform of A, and out_data[2m+1] is coefficient m of the 16-point transform of B.
- R5: Results are exact two's-complement integers of width DW+5. With DW = 8 and all samples at −128 or at +127, the 32-point DC term is −4096 or +4064, with no wrap.
- R6: out_valid rises exactly four clock cycles after in_valid is sampled high. Back-to-back transactions emerge on back-to-back cycles. Idle input cycles yield no valid output.
- R7: The mode is captured together with its samples. Consecutive transactions with different modes are each computed in their own mode.
- R8: The unused code 2'b10 is computed as mode 2'b00. out_mode_err is high in exactly the cycle that result is valid, and low for every legal-mode result and whenever out_valid is low.
- R9: A synchronous active-high reset clears out_valid and out_mode_err and discards transactions in flight. out_valid stays low for the first four cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Samples and mode are presented this cycle |
| in_mode | input | 2 | Transform layout: 00 four 8-point, 01 two 16-point, 11 one 32-point, 10 unused |
| in_data | input | 32×DW | Signed samples, element i is sample i |
| out_valid | output | 1 | Coefficients are valid this cycle |
| out_mode_err | output | 1 | The result on the outputs came from the unused mode code |
| out_data | output | 32×(DW+5) | Signed coefficients, element i is coefficient i of the chosen layout |

## Verification
The bound checker watches the control path on every cycle. It checks the fixed four-cycle spacing from in_valid to out_valid. It checks that the error flag matches the mode sampled four cycles earlier and is never raised without a valid result. It checks that nothing valid appears right after reset. The coefficient values themselves can only be judged by the bench scenarios, which compare every output word with a recursive software model whose kernel comes from cosine arithmetic. These scenarios include mode switches on every cycle, full-scale inputs at both signs, the unused code, and a reset that lands on a full pipeline.

// File: rtl/dct_rcfg_pkg.sv
package dct_rcfg_pkg;

    localparam int NPTS   = 32;
    localparam int CORE_N = 8;
    localparam int NCORE  = NPTS / CORE_N;
    localparam int HALF16 = 16;

    typedef enum logic [1:0] {
        MODE_4X8  = 2'b00,
        MODE_2X16 = 2'b01,
        MODE_BAD  = 2'b10,
        MODE_1X32 = 2'b11
    } mode_e;

    // Ternary kernel as two masks per row: bit c of row r set in KPOS
    // means +1 at column c, set in KNEG means -1, neither means 0.
    localparam logic [7:0][7:0] KPOS = {
        8'h54, 8'h24, 8'h49, 8'h99, 8'h31, 8'h81, 8'h07, 8'hFF
    };
    localparam logic [7:0][7:0] KNEG = {
        8'h2A, 8'h42, 8'h92, 8'h66, 8'h8C, 8'h18, 8'hE0, 8'h00
    };

    // Output width: one bit per butterfly level plus the growth of an
    // eight-term signed sum.
    function automatic int dct_out_w(input int dw);
        return dw + 2 + $clog2(CORE_N);
    endfunction

endpackage

// File: rtl/dct_rcfg_bfly.sv
module dct_rcfg_bfly #(
    parameter int N  = 32,
    parameter int IW = 8
) (
    input  logic [N-1:0][IW-1:0]   x,
    output logic [N/2-1:0][IW:0]   s,
    output logic [N/2-1:0][IW:0]   d
);
    localparam int HALF = N / 2;
    localparam int SW   = IW + 1;

    for (genvar i = 0; i < HALF; i++) begin : g_pair
        assign s[i] = SW'(signed'(x[i])) + SW'(signed'(x[N-1-i]));
        assign d[i] = SW'(signed'(x[i])) - SW'(signed'(x[N-1-i]));
    end

endmodule

// File: rtl/dct_rcfg_core8.sv
module dct_rcfg_core8
    import dct_rcfg_pkg::*;
#(
    parameter int IW = 10,
    parameter int OW = 13
) (
    input  logic [CORE_N-1:0][IW-1:0] x,
    output logic [CORE_N-1:0][OW-1:0] y
);
    always_comb begin
        for (int r = 0; r < CORE_N; r++) begin
            y[r] = '0;
            for (int c = 0; c < CORE_N; c++) begin
                if (KPOS[r][c])
                    y[r] = y[r] + OW'(signed'(x[c]));
                else if (KNEG[r][c])
                    y[r] = y[r] - OW'(signed'(x[c]));
            end
        end
    end

endmodule

// File: rtl/dct_rcfg_perm.sv
module dct_rcfg_perm
    import dct_rcfg_pkg::*;
#(
    parameter int OW = 13
) (
    input  mode_e                                 mode,
    input  logic [NCORE-1:0][CORE_N-1:0][OW-1:0]  y,
    output logic [NPTS-1:0][OW-1:0]               z
);
    always_comb begin
        z = '0;
        unique case (mode)
            MODE_1X32: begin
                // even coefficients from the sum-side 16-point pair (cores 0,1),
                // odd ones from the difference-side pair (cores 2,3)
                for (int k = 0; k < CORE_N; k++) begin
                    z[4*k]     = y[0][k];
                    z[4*k + 1] = y[2][k];
                    z[4*k + 2] = y[1][k];
                    z[4*k + 3] = y[3][k];
                end
            end
            MODE_2X16: begin
                for (int g = 0; g < 2; g++) begin
                    for (int k = 0; k < CORE_N; k++) begin
                        z[16*g + 2*k]     = y[2*g][k];
                        z[16*g + 2*k + 1] = y[2*g + 1][k];
                    end
                end
            end
            default: begin
                for (int c = 0; c < NCORE; c++) begin
                    for (int k = 0; k < CORE_N; k++) begin
                        z[CORE_N*c + k] = y[c][k];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/dct_rcfg_array.sv
module dct_rcfg_array
    import dct_rcfg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic [1:0]                            in_mode,
    input  logic [NPTS-1:0][DW-1:0]               in_data,
    output logic                                  out_valid,
    output logic                                  out_mode_err,
    output logic [NPTS-1:0][dct_out_w(DW)-1:0]    out_data
);
    localparam int W1 = DW + 1;
    localparam int W2 = DW + 2;
    localparam int OW = dct_out_w(DW);

    // stage 1: capture
    logic                      v1, e1;
    mode_e                     m1;
    logic [NPTS-1:0][DW-1:0]   x1;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            e1 <= 1'b0;
        end else begin
            v1 <= in_valid;
            e1 <= in_valid && (in_mode == MODE_BAD);
        end
        if (in_valid) begin
            m1 <= (in_mode == MODE_BAD) ? MODE_4X8 : mode_e'(in_mode);
            x1 <= in_data;
        end
    end

    // stage 2: 32-point butterfly or bypass
    logic [HALF16-1:0][W1-1:0]        s32, d32;
    logic [1:0][HALF16-1:0][W1-1:0]   grp_n, grp;
    logic                             v2, e2;
    mode_e                            m2;

    dct_rcfg_bfly #(.N(NPTS), .IW(DW)) u_bfly32 (
        .x (x1),
        .s (s32),
        .d (d32)
    );

    for (genvar i = 0; i < HALF16; i++) begin : g_sel32
        assign grp_n[0][i] = (m1 == MODE_1X32) ? s32[i] : W1'(signed'(x1[i]));
        assign grp_n[1][i] = (m1 == MODE_1X32) ? d32[i] : W1'(signed'(x1[HALF16 + i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v2 <= 1'b0;
            e2 <= 1'b0;
        end else begin
            v2 <= v1;
            e2 <= v1 && e1;
        end
        if (v1) begin
            m2  <= m1;
            grp <= grp_n;
        end
    end

    // stage 3: 16-point butterflies or bypass
    logic                                    sel16;
    logic [NCORE-1:0][CORE_N-1:0][W2-1:0]    core_n, core_in;
    logic                                    v3, e3;
    mode_e                                   m3;

    assign sel16 = (m2 != MODE_4X8);

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [CORE_N-1:0][W2-1:0] s16, d16;

        dct_rcfg_bfly #(.N(HALF16), .IW(W1)) u_bfly16 (
            .x (grp[g]),
            .s (s16),
            .d (d16)
        );

        for (genvar k = 0; k < CORE_N; k++) begin : g_sel16
            assign core_n[2*g][k]     = sel16 ? s16[k] : W2'(signed'(grp[g][k]));
            assign core_n[2*g + 1][k] = sel16 ? d16[k] : W2'(signed'(grp[g][CORE_N + k]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v3 <= 1'b0;
            e3 <= 1'b0;
        end else begin
            v3 <= v2;
            e3 <= v2 && e2;
        end
        if (v2) begin
            m3      <= m2;
            core_in <= core_n;
        end
    end

    // stage 4: kernel cores and output reordering
    logic [NCORE-1:0][CORE_N-1:0][OW-1:0] core_out;
    logic [NPTS-1:0][OW-1:0]              perm_out;
    logic                                 v4, e4;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        dct_rcfg_core8 #(.IW(W2), .OW(OW)) u_core (
            .x (core_in[c]),
            .y (core_out[c])
        );
    end

    dct_rcfg_perm #(.OW(OW)) u_perm (
        .mode (m3),
        .y    (core_out),
        .z    (perm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v4 <= 1'b0;
            e4 <= 1'b0;
        end else begin
            v4 <= v3;
            e4 <= v3 && e3;
        end
        if (v3) begin
            out_data <= perm_out;
        end
    end

    assign out_valid    = v4;
    assign out_mode_err = e4;

endmodule

// File: rtl/dct_rcfg_sva.sv
module dct_rcfg_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [1:0] in_mode,
    input logic       out_valid,
    input logic       out_mode_err
);
    // cycles since reset release, saturating at the pipeline depth
    logic [2:0] since;

    always_ff @(posedge clk) begin
        if (rst)
            since <= 3'd0;
        else if (since != 3'd4)
            since <= since + 3'd1;
    end

    // R6: fixed four-cycle spacing between input and output valid
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        (since == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R8: flag reflects the unused code presented four cycles earlier
    a_r8_err_source: assert property (@(posedge clk) disable iff (rst)
        (since == 3'd4) |-> (out_mode_err == $past(in_valid && (in_mode == 2'b10), 4)));

    // R8: flag never appears without a valid result
    a_r8_err_with_valid: assert property (@(posedge clk) disable iff (rst)
        out_mode_err |-> out_valid);

    // R9: pipeline is empty right after reset release
    a_r9_quiet_start: assert property (@(posedge clk) disable iff (rst)
        (since != 3'd4) |-> (!out_valid && !out_mode_err));

endmodule

bind dct_rcfg_array dct_rcfg_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_mode      (in_mode),
    .out_valid    (out_valid),
    .out_mode_err (out_mode_err)
);

// File: tb/dct_rcfg_array_test.sv
module dct_rcfg_array_test;
    import dct_rcfg_pkg::*;

    localparam int DW = 8;
    localparam int OW = dct_out_w(DW);

    typedef int v8_t[8];
    typedef int v16_t[16];
    typedef int v32_t[32];

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       in_valid = 1'b0;
    logic [1:0]                 in_mode = 2'b00;
    logic [NPTS-1:0][DW-1:0]    in_data = '0;
    logic                       out_valid;
    logic                       out_mode_err;
    logic [NPTS-1:0][OW-1:0]    out_data;

    always #5 clk = ~clk;

    dct_rcfg_array #(.DW(DW)) uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_mode      (in_mode),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_mode_err (out_mode_err),
        .out_data     (out_data)
    );

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;
    int  kern[8][8];

    // history of the last four driven cycles, [3] is the oldest
    bit         hv[4];
    logic [1:0] hm[4];
    v32_t       hx[4];
    string      ht[4];

    // R2: kernel derived from the cosine basis
    initial begin
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                real e;
                e = (r == 0) ? 1.0 / $sqrt(2.0) : 1.0;
                kern[r][c] = int'(2.0 * e * $sqrt(2.0 / 8.0)
                                  * $cos((2 * c + 1) * r * 3.14159265358979 / 16.0));
            end
        end
    end

    function automatic v8_t m8(v8_t x);
        v8_t y;
        for (int r = 0; r < 8; r++) begin
            y[r] = 0;
            for (int c = 0; c < 8; c++) y[r] += kern[r][c] * x[c];
        end
        return y;
    endfunction

    function automatic v16_t m16(v16_t x);
        v8_t a, b, ya, yb;
        v16_t y;
        for (int i = 0; i < 8; i++) begin
            a[i] = x[i] + x[15 - i];
            b[i] = x[i] - x[15 - i];
        end
        ya = m8(a);
        yb = m8(b);
        for (int k = 0; k < 8; k++) begin
            y[2*k]     = ya[k];
            y[2*k + 1] = yb[k];
        end
        return y;
    endfunction

    function automatic v32_t m32(v32_t x);
        v16_t a, b, ya, yb;
        v32_t y;
        for (int i = 0; i < 16; i++) begin
            a[i] = x[i] + x[31 - i];
            b[i] = x[i] - x[31 - i];
        end
        ya = m16(a);
        yb = m16(b);
        for (int k = 0; k < 16; k++) begin
            y[2*k]     = ya[k];
            y[2*k + 1] = yb[k];
        end
        return y;
    endfunction

    function automatic v32_t model(logic [1:0] md, v32_t x);
        v32_t y;
        if (md == 2'b11) begin
            y = m32(x);
        end else if (md == 2'b01) begin
            for (int h = 0; h < 2; h++) begin
                v16_t p, q;
                for (int i = 0; i < 16; i++) p[i] = x[16*h + i];
                q = m16(p);
                for (int i = 0; i < 16; i++) y[16*h + i] = q[i];
            end
        end else begin
            for (int g = 0; g < 4; g++) begin
                v8_t p, q;
                for (int i = 0; i < 8; i++) p[i] = x[8*g + i];
                q = m8(p);
                for (int i = 0; i < 8; i++) y[8*g + i] = q[i];
            end
        end
        return y;
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== hv[3]) begin
            failures++;
            $display("FAIL R6 out_valid actual=%b expected=%b", out_valid, hv[3]);
        end
        if (hv[3] && out_valid === 1'b1) begin
            v32_t exp;
            int   bad;
            exp = model(hm[3], hx[3]);
            bad = -1;
            for (int i = 0; i < 32; i++) begin
                int act;
                act = int'(signed'(out_data[i]));
                if (bad < 0 && act != exp[i]) bad = i;
            end
            checks++;
            if (bad >= 0) begin
                failures++;
                $display("FAIL %s coef[%0d] actual=%0d expected=%0d",
                         ht[3], bad, int'(signed'(out_data[bad])), exp[bad]);
            end
            checks++;
            if (out_mode_err !== (hm[3] == 2'b10)) begin
                failures++;
                $display("FAIL R8 out_mode_err actual=%b expected=%b",
                         out_mode_err, (hm[3] == 2'b10));
            end
        end else if (!hv[3]) begin
            checks++;
            if (out_mode_err !== 1'b0) begin
                failures++;
                $display("FAIL R8 out_mode_err idle actual=%b expected=0", out_mode_err);
            end
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 4; i++) begin
            hv[i] = 1'b0;
            hm[i] = 2'b00;
            ht[i] = "";
        end
    endtask

    task automatic cycle(bit v, logic [1:0] md, v32_t x, string tag);
        @(negedge clk);
        check_out();
        for (int i = 3; i > 0; i--) begin
            hv[i] = hv[i-1];
            hm[i] = hm[i-1];
            hx[i] = hx[i-1];
            ht[i] = ht[i-1];
        end
        hv[0] = v;
        hm[0] = md;
        hx[0] = x;
        ht[0] = tag;
        in_valid = v;
        in_mode  = md;
        for (int i = 0; i < 32; i++) in_data[i] = DW'(x[i]);
    endtask

    function automatic string mode_tag(logic [1:0] md);
        case (md)
            2'b00:   return "R1";
            2'b01:   return "R3";
            2'b11:   return "R4";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        v32_t x;
        void'($urandom(32'd51173));
        clear_hist();
        for (int i = 0; i < 32; i++) hx[0][i] = 0;
        for (int i = 1; i < 4; i++) hx[i] = hx[0];

        // R9: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_mode_err !== 1'b0) begin
            failures++;
            $display("FAIL R9 reset outputs actual=%b%b expected=00", out_valid, out_mode_err);
        end
        rst = 1'b0;

        // R1: all-zero input
        for (int i = 0; i < 32; i++) x[i] = 0;
        cycle(1'b1, 2'b00, x, "R1");

        // R7: ramp in every mode back to back, R2 via mode 00
        for (int i = 0; i < 32; i++) x[i] = i - 16;
        cycle(1'b1, 2'b00, x, "R2");
        cycle(1'b1, 2'b01, x, "R3");
        cycle(1'b1, 2'b11, x, "R7");
        cycle(1'b1, 2'b01, x, "R7");

        // R5: full-scale extremes
        for (int i = 0; i < 32; i++) x[i] = -128;
        cycle(1'b1, 2'b11, x, "R5");
        for (int i = 0; i < 32; i++) x[i] = 127;
        cycle(1'b1, 2'b11, x, "R5");
        for (int i = 0; i < 32; i++) x[i] = (i % 2) ? -128 : 127;
        cycle(1'b1, 2'b11, x, "R5");
        cycle(1'b1, 2'b01, x, "R5");
        cycle(1'b1, 2'b00, x, "R5");

        // R8: unused code, then idle gap (R6)
        for (int i = 0; i < 32; i++) x[i] = (i * 37) % 200 - 100;
        cycle(1'b1, 2'b10, x, "R8");
        cycle(1'b0, 2'b11, x, "R6");
        cycle(1'b1, 2'b11, x, "R4");
        cycle(1'b0, 2'b00, x, "R6");
        cycle(1'b0, 2'b00, x, "R6");

        // random mix
        for (int n = 0; n < 600; n++) begin
            bit         v;
            logic [1:0] md;
            int         pick;
            v    = ($urandom_range(3, 0) != 0);
            pick = $urandom_range(9, 0);
            md   = (pick < 3) ? 2'b00 : (pick < 6) ? 2'b01 : (pick < 9) ? 2'b11 : 2'b10;
            for (int i = 0; i < 32; i++) x[i] = $urandom_range(255, 0) - 128;
            cycle(v, md, x, mode_tag(md));
        end

        // R9: reset with a full pipeline discards everything in flight
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 32; j++) x[j] = $urandom_range(255, 0) - 128;
            cycle(1'b1, 2'b11, x, "R4");
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_hist();
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, 2'b00, x, "R9");
        end
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R9 after reset out_valid actual=%b expected=0", out_valid);
        end

        // drain
        for (int i = 0; i < 6; i++) cycle(1'b0, 2'b00, x, "R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule